// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer with selectable bit mapping

This block turns one parallel RGB pixel, together with the horizontal sync, vertical sync and data-enable flags, into seven serial bits on each of up to four data lanes. It also drives a clock lane whose repeating seven-bit pattern marks the word boundaries. It runs on a single fast clock at seven times the pixel rate and counts its own slot position 0 to 6. The clock lane is high for slots 0, 1, 5 and 6 and low for slots 2 to 4. Upstream logic uses that lane as its pixel clock and presents each pixel before the rising edge that starts slot 0.

A static two-bit mode input selects the bit-to-slot permutation. Mode 0 is an 18-bit three-lane mapping. Mode 1 is a 24-bit mapping in which lanes 0 to 2 carry the upper six bits of each colour and lane 3 carries the two low bits. Mode 2 is a 24-bit mapping in which lanes 0 to 2 carry the low six bits and lane 3 carries the top two bits. Mode 3 is not a legal value and behaves as mode 2. Each lane is one single-ended bit per fast clock. The differential buffers belong to the pad ring.

Top module: `lvds_serializer`

## Requirements
- R1: While rst_n is low, all four data lanes and the clock lane are 0 and the slot counter is held at 0. After release, the k-th rising edge presents slot k mod 7, and the first full word is taken at the 7th edge. Data lanes carry 0 until then.
- R2: The clock lane presents 1,1,0,0,0,1,1 for slots 0 through 6. Each slot lasts exactly one fast clock and a word lasts seven.
- R3: In mode 0, taking c6 as bits [7:2] of each colour: lane 0 sends g6[0], then r6[5] down to r6[0]. Lane 1 sends b6[1], b6[0], then g6[5] down to g6[1]. Lane 2 sends de, vsync, hsync, then b6[5] down to b6[2]. The lists are in slot order 0 to 6.
- R4: In mode 0, lane 3 stays 0 in every slot, and bits [1:0] of each colour input have no effect on any lane.
- R5: In mode 1, lanes 0 to 2 follow the R3 layout with c6 = bits [7:2]. Lane 3 sends 0, b[1], b[0], g[1], g[0], r[1], r[0] in slots 0 to 6.
- R6: In mode 2, lanes 0 to 2 follow the R3 layout with c6 = bits [5:0]. Lane 3 sends 0, b[7], b[6], g[7], g[6], r[7], r[6] in slots 0 to 6.
- R7: Control slots carry data enable in lane 2 slot 0, vsync in lane 2 slot 1 and hsync in lane 2 slot 2. Lane 3 slot 0 is always 0.
- R8: Mode value 3 produces exactly the output of mode 2.
- R9: The pixel, the sync flags and the mode are sampled only at the edge that ends slot 6. Changes at any other time do not alter the word being sent.
- R10: The same edge that samples a new pixel presents slot 0 of that pixel on all lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mapping select: 0 = 18-bit, 1 = 24-bit high-aligned, 2 or 3 = 24-bit low-aligned |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync flag |
| vsync | input | 1 | Vertical sync flag |
| de | input | 1 | Data enable flag |
| lane_data | output | 4 | Serial data lanes 0 to 3, one bit per clock |
| lane_clk | output | 1 | Clock lane pattern marking word boundaries |

## Verification
Two things happen at the slot-6-to-slot-0 edge: the shadow takes in a new pixel, and slot 0 of that new pixel goes onto the lanes. Each word is offered just before that edge. The bench then loads unrelated random values into every input, mode included, right after slot 0 has been checked. Every later slot of the word must still match the pixel offered before the edge, computed by a bench function, and slot 0 must already belong to the new pixel. This shows that the capture and the emission line up and that a mid-word change leaks nowhere.

// File: rtl/lvds_serializer.sv
module lvds_serializer #(
  parameter int CW    = 8,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] red,
  input  logic [CW-1:0] grn,
  input  logic [CW-1:0] blu,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          de,
  output logic [LANES-1:0] lane_data,
  output logic          lane_clk
);
  localparam int SLOTS = 7;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  logic [SW-1:0] slot_q;
  logic [LANES-1:0][SLOTS-1:0] shadow_q;
  logic [LANES-1:0][SLOTS-1:0] word_in;
  logic [LANES-1:0][SLOTS-1:0] src;
  logic [LANES-1:0] data_q;
  logic clk_q;

  wire last = (slot_q == SW'(SLOTS - 1));
  wire [SW-1:0] nxt = last ? '0 : SW'(slot_q + SW'(1));
  wire [1:0] msel = (mode == 2'd3) ? 2'd2 : mode;
  wire hi = (msel != 2'd2);

  wire [5:0] r6 = hi ? red[7:2] : red[5:0];
  wire [5:0] g6 = hi ? grn[7:2] : grn[5:0];
  wire [5:0] b6 = hi ? blu[7:2] : blu[5:0];

  assign word_in[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
  assign word_in[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
  assign word_in[2] = {b6[2], b6[3], b6[4], b6[5], hsync, vsync, de};

  always_comb begin
    case (msel)
      2'd1:    word_in[3] = {red[0], red[1], grn[0], grn[1], blu[0], blu[1], 1'b0};
      2'd2:    word_in[3] = {red[6], red[7], grn[6], grn[7], blu[6], blu[7], 1'b0};
      default: word_in[3] = '0;
    endcase
  end

  assign src = last ? word_in : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      shadow_q <= '0;
      clk_q    <= 1'b0;
    end else begin
      slot_q <= nxt;
      clk_q  <= CLK_PAT[nxt];
      if (last) shadow_q <= word_in;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[l] <= 1'b0;
      else        data_q[l] <= src[l][nxt];
    end
  end

  assign lane_data = data_q;
  assign lane_clk  = clk_q;
endmodule

// File: rtl/lvds_serializer_chk.sv
module lvds_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic [3:0]  lane_data,
  input logic        lane_clk,
  input logic [27:0] shadow
);
  localparam logic [6:0] PAT = 7'b1100011;
  logic [2:0] c;
  logic [1:0] cap_mode;
  logic run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c <= '0; cap_mode <= '0; run <= 1'b0;
    end else begin
      run <= 1'b1;
      c <= (c == 3'd6) ? 3'd0 : c + 3'd1;
      if (c == 3'd6) cap_mode <= mode;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (lane_data == 4'd0 && !lane_clk));

  assert_clk_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> lane_clk == PAT[c]);

  assert_lane3_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cap_mode == 2'd0) |-> !lane_data[3]);

  assert_ctl3_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 3'd0) |-> !lane_data[3]);

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && c != 3'd0) |-> $stable(shadow));
endmodule

bind lvds_serializer lvds_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .lane_data(lane_data), .lane_clk(lane_clk), .shadow(shadow_q)
);

// File: tb/tb_lvds_serializer.sv
module tb_lvds_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] red = '0, grn = '0, blu = '0;
  logic hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic [3:0] lane_data;
  logic lane_clk;
  int errs = 0, checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  lvds_serializer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .red(red), .grn(grn), .blu(blu),
    .hsync(hsync), .vsync(vsync), .de(de), .lane_data(lane_data), .lane_clk(lane_clk)
  );

  function automatic logic exp_clk(input int s);
    return (s == 0 || s == 1 || s == 5 || s == 6);
  endfunction

  function automatic logic [3:0] exp_data(input logic [7:0] r, g, b,
      input logic hs, vs, en, input logic [1:0] md, input int s);
    logic [1:0] m;
    logic [5:0] r6, g6, b6;
    logic [3:0] d;
    m = (md == 2'd3) ? 2'd2 : md;
    r6 = (m == 2'd2) ? r[5:0] : r[7:2];
    g6 = (m == 2'd2) ? g[5:0] : g[7:2];
    b6 = (m == 2'd2) ? b[5:0] : b[7:2];
    case (s)
      0: d = {1'b0, en, b6[1], g6[0]};
      1: d = {(m == 0) ? 1'b0 : (m == 1) ? b[1] : b[7], vs, b6[0], r6[5]};
      2: d = {(m == 0) ? 1'b0 : (m == 1) ? b[0] : b[6], hs, g6[5], r6[4]};
      3: d = {(m == 0) ? 1'b0 : (m == 1) ? g[1] : g[7], b6[5], g6[4], r6[3]};
      4: d = {(m == 0) ? 1'b0 : (m == 1) ? g[0] : g[6], b6[4], g6[3], r6[2]};
      5: d = {(m == 0) ? 1'b0 : (m == 1) ? r[1] : r[7], b6[3], g6[2], r6[1]};
      default: d = {(m == 0) ? 1'b0 : (m == 1) ? r[0] : r[6], b6[2], g6[1], r6[0]};
    endcase
    return d;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic scramble();
    red = 8'($urandom); grn = 8'($urandom); blu = 8'($urandom);
    {hsync, vsync, de} = 3'($urandom);
    mode = 2'($urandom);
  endtask

  // entry: at a negedge, next rising edge ends slot 6
  task automatic send(input logic [7:0] r, g, b, input logic hs, vs, en, input logic [1:0] md);
    string tag;
    tag = (md == 0) ? "R3 R4 R7 R9 R10" : (md == 1) ? "R5 R7 R9 R10" :
          (md == 2) ? "R6 R7 R9 R10" : "R8 R9 R10";
    red = r; grn = g; blu = b; hsync = hs; vsync = vs; de = en; mode = md;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      chk(tag, {1'b0, lane_data}, {1'b0, exp_data(r, g, b, hs, vs, en, md, s)});
      chk("R2", {4'd0, lane_clk}, {4'd0, exp_clk(s)});
      if (s == 0) scramble();
    end
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      chk("R1", {lane_data, 1'b0}, 5'd0);
      chk("R2", {4'd0, lane_clk}, {4'd0, exp_clk(k)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {lane_data, lane_clk}, 5'd0);
    leave_reset();

    send(8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd0);
    send(8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd1);
    send(8'hFC, 8'h00, 8'hFC, 1, 0, 1, 2'd0);
    send(8'hFF, 8'hFF, 8'hFF, 0, 1, 0, 2'd0);
    send(8'h03, 8'h03, 8'h03, 1, 0, 0, 2'd0);
    send(8'h03, 8'h01, 8'h02, 0, 0, 1, 2'd1);
    send(8'hC0, 8'h40, 8'h80, 1, 1, 0, 2'd2);
    send(8'hA5, 8'h5A, 8'h3C, 0, 1, 1, 2'd3);
    send(8'hA5, 8'h5A, 8'h3C, 0, 1, 1, 2'd2);

    // reset in mid-word
    red = 8'hFF; grn = 8'hFF; blu = 8'hFF; mode = 2'd2; {hsync, vsync, de} = 3'b111;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1", {lane_data, lane_clk}, 5'd0);
    @(negedge clk);
    chk("R1", {lane_data, lane_clk}, 5'd0);
    leave_reset();

    for (int i = 0; i < 80; i++)
      send(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom));
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd1234));
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule